// File: doc/BRIEF.md
# Prioritized Serial Downstream Frame Scheduler

This block sends fixed-width command frames and data frames, one after another, on a single synchronous serial output. Software loads a 16-bit command word by writing the command register. It loads a 16-bit data word by writing the data register. It requests a data frame with a separate pulse. Each request is held in its own pending flag until the frame it asked for begins. When both flags are set, the command frame goes out first. A request that arrives while a frame is being shifted waits for the frame boundary. The next frame then follows without a gap.

Bits move out MSB first, one per pulse of a shift-clock enable input. Frames begin only on such a pulse. A frame begins on the first enable pulse after the channel goes idle, or on the enable pulse that ends the last bit of the current frame. On that clock the shift register loads the selected word and the pending flag of that frame clears. Two flags show whether the active frame is a command or data frame. A counter shows how many shift periods have passed in the current frame.

The mode input selects between two behaviours. Mode 0 is triggered mode: frames go out only on request, and the channel goes idle when nothing is pending. Mode 1 is repetition mode: the data word is sent again and again, and a pending command is inserted at the next frame boundary.

Top module: `ds_frame_sched`

## Requirements
- R1: After reset, sdo, frame_active, cmd_active and data_active are 0, both pending flags are 0 and bit_cnt is 0.
- R2: A cmd_wr pulse stores cmd_wdata and sets cmd_pend on the next clock. If the channel is idle, a command frame begins on the next clock with shift_en high. The frame holds that word, sent MSB first, one bit per shift_en pulse. cmd_active is 1 and data_active is 0 for all 16 bits.
- R3: A data_wr pulse stores data_wdata. A set_dp pulse sets data_pend. The data frame then holds the stored data word, with data_active 1 and cmd_active 0.
- R4: A pending flag clears on the clock that drives the first bit of its own frame. The other flag is not changed. A write in that same clock keeps the flag set.
- R5: When both flags are set, the command frame goes first. A data frame keeps waiting while new command requests arrive before each frame boundary.
- R6: A request made during a frame does not change that frame's bits. The requested frame follows at once: its first bit is driven on the shift_en pulse that ends the last bit of the current frame.
- R7: In mode 0, if nothing is pending when a frame ends, the channel goes idle with sdo, frame_active, cmd_active and data_active all 0.
- R8: bit_cnt is 0 on the first bit of a frame and rises by one at each shift_en pulse up to 15. It holds its value between pulses.
- R9: In mode 1 (rep_mode=1), data frames repeat back-to-back without set_dp. A command written during a frame is inserted as the next frame, and data frames resume after it.
- R10: A second cmd_wr while a command is still pending replaces the held word. Only one command frame, holding the latest word, is sent.
- R11: frame_active is 1 exactly when cmd_active or data_active is 1. cmd_active and data_active are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command word |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Data word |
| set_dp | input | 1 | Data frame request strobe |
| rep_mode | input | 1 | 0 triggered, 1 data repetition |
| shift_en | input | 1 | Shift-clock enable, one bit per pulse |
| sdo | output | 1 | Serial data out, 0 when idle |
| frame_active | output | 1 | A frame is being shifted |
| cmd_active | output | 1 | Active frame is a command frame |
| data_active | output | 1 | Active frame is a data frame |
| cmd_pend | output | 1 | Command request pending |
| data_pend | output | 1 | Data request pending |
| bit_cnt | output | 4 | Shift periods elapsed in current frame |

## Verification
The bench first sends single command and data frames from idle. These checks tell the bit order and frame type apart and show that the channel returns to idle. Requests are then set up while shifting is held off, to check that both flags are set and that the command wins. More commands are then injected in the middle of frames. This separates deferral at the boundary from corruption of the active frame, and checks that data can be starved by a stream of commands. Further tests cover a slow shift enable, a command overwritten while pending, and repetition mode with a command inserted part way through. The slow-enable test separates counting shift periods from counting clocks. The overwrite test separates keeping the latest word from sending two frames. The repetition test shows the command is inserted once and data frames then resume.

// File: rtl/ds_pkg.sv
package ds_pkg;
  typedef enum logic [1:0] {FK_NONE = 2'd0, FK_CMD = 2'd1, FK_DATA = 2'd2} frm_kind_e;

  // Which frame goes out at the next boundary; commands always win.
  function automatic frm_kind_e pick_kind(input logic cmd_p, input logic data_p,
                                          input logic rep);
    if (cmd_p)             return FK_CMD;
    else if (data_p || rep) return FK_DATA;
    else                   return FK_NONE;
  endfunction
endpackage

// File: rtl/ds_pend_regs.sv
module ds_pend_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_wr,
  input  logic [W-1:0] cmd_wdata,
  input  logic         data_wr,
  input  logic [W-1:0] data_wdata,
  input  logic         set_dp,
  input  logic         clr_cmd,
  input  logic         clr_data,
  output logic [W-1:0] cmd_word,
  output logic [W-1:0] data_word,
  output logic         cmd_pend,
  output logic         data_pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_word  <= '0;
      data_word <= '0;
      cmd_pend  <= 1'b0;
      data_pend <= 1'b0;
    end else begin
      if (cmd_wr) cmd_word <= cmd_wdata;
      if (data_wr) data_word <= data_wdata;
      if (cmd_wr) cmd_pend <= 1'b1;
      else if (clr_cmd) cmd_pend <= 1'b0;
      if (set_dp) data_pend <= 1'b1;
      else if (clr_data) data_pend <= 1'b0;
    end
  end

  AST_CMD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> cmd_pend); // R2
  AST_DP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_dp |=> data_pend); // R3
endmodule

// File: rtl/ds_shifter.sv
module ds_shifter
  import ds_pkg::*;
#(
  parameter int W = 16,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  frm_kind_e     next_kind,
  input  logic [W-1:0]  next_word,
  output logic          start,
  output logic          sdo,
  output logic          active,
  output logic          cmd_active,
  output logic          data_active,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0] sreg;
  frm_kind_e    kind;
  logic         last_bit;
  logic         boundary;

  assign active      = (kind != FK_NONE);
  assign last_bit    = active && (cnt == LAST);
  assign boundary    = shift_en && (!active || last_bit);
  assign start       = boundary && (next_kind != FK_NONE);
  assign sdo         = active ? sreg[W-1] : 1'b0;
  assign cmd_active  = (kind == FK_CMD);
  assign data_active = (kind == FK_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
      cnt  <= '0;
      kind <= FK_NONE;
    end else if (start) begin
      sreg <= next_word;
      cnt  <= '0;
      kind <= next_kind;
    end else if (boundary) begin
      sreg <= '0;
      cnt  <= '0;
      kind <= FK_NONE;
    end else if (shift_en && active) begin
      sreg <= {sreg[W-2:0], 1'b0};
      cnt  <= cnt + 1'b1;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !shift_en) |=> $stable(cnt)); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && shift_en && !last_bit) |=> (cnt == $past(cnt) + 1'b1)); // R8
  AST_IDLE_SDO: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sdo); // R7
endmodule

// File: rtl/ds_frame_sched.sv
module ds_frame_sched
  import ds_pkg::*;
#(
  parameter int W = 16,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [W-1:0]  cmd_wdata,
  input  logic          data_wr,
  input  logic [W-1:0]  data_wdata,
  input  logic          set_dp,
  input  logic          rep_mode,
  input  logic          shift_en,
  output logic          sdo,
  output logic          frame_active,
  output logic          cmd_active,
  output logic          data_active,
  output logic          cmd_pend,
  output logic          data_pend,
  output logic [CW-1:0] bit_cnt
);
  logic [W-1:0] cmd_word, data_word, next_word;
  frm_kind_e    next_kind;
  logic         start, start_cmd, start_data;

  assign next_kind  = pick_kind(cmd_pend, data_pend, rep_mode);
  assign next_word  = (next_kind == FK_CMD) ? cmd_word : data_word;
  assign start_cmd  = start && (next_kind == FK_CMD);
  assign start_data = start && (next_kind == FK_DATA);

  ds_pend_regs #(.W(W)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata),
    .set_dp(set_dp), .clr_cmd(start_cmd), .clr_data(start_data),
    .cmd_word(cmd_word), .data_word(data_word),
    .cmd_pend(cmd_pend), .data_pend(data_pend)
  );

  ds_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .next_kind(next_kind), .next_word(next_word),
    .start(start), .sdo(sdo), .active(frame_active),
    .cmd_active(cmd_active), .data_active(data_active), .cnt(bit_cnt)
  );

  AST_ONE_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_active && data_active) && (frame_active == (cmd_active || data_active))); // R11
  AST_CMD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !cmd_wr) |=> (!cmd_pend && cmd_active)); // R4
  AST_CMD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start_data |-> !cmd_pend); // R5
  AST_DATA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && data_pend) |=> data_pend); // R4
endmodule

// File: tb/sim_ds_frame_sched.sv
`timescale 1ns/1ps
module sim_ds_frame_sched;
  logic clk = 0, rst_n = 0;
  logic cmd_wr = 0, data_wr = 0, set_dp = 0, rep_mode = 0, shift_en = 0;
  logic [15:0] cmd_wdata = 0, data_wdata = 0;
  logic sdo, frame_active, cmd_active, data_active, cmd_pend, data_pend;
  logic [3:0] bit_cnt;
  int total = 0, fails = 0;
  int en_period = 0, en_ctr = 0;

  always #2.5 clk = ~clk;

  ds_frame_sched u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata), .set_dp(set_dp),
    .rep_mode(rep_mode), .shift_en(shift_en), .sdo(sdo),
    .frame_active(frame_active), .cmd_active(cmd_active), .data_active(data_active),
    .cmd_pend(cmd_pend), .data_pend(data_pend), .bit_cnt(bit_cnt)
  );

  always @(negedge clk) begin
    if (en_period == 0) shift_en <= 1'b0;
    else begin
      shift_en <= (en_ctr == 0);
      en_ctr   <= (en_ctr + 1 >= en_period) ? 0 : en_ctr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_period(input int p);
    en_ctr = 0;
    en_period = p;
  endtask

  task automatic wr_cmd(input logic [15:0] w);
    cmd_wr = 1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic wr_data(input logic [15:0] w);
    data_wr = 1; data_wdata = w;
    @(negedge clk); data_wr = 0;
  endtask

  task automatic req_data();
    set_dp = 1;
    @(negedge clk); set_dp = 0;
  endtask

  task automatic check_idle(input string req);
    chk(!frame_active && !sdo && !cmd_active && !data_active, req, "idle after frame",
        {frame_active, sdo, cmd_active, data_active}, 0);
  endtask

  // Captures one frame; optionally injects a request after sampling bit inj_k.
  task automatic capture(input logic [15:0] exp_word, input bit exp_cmd,
                         input int inj_k, input bit inj_cmd, input logic [15:0] inj_word,
                         input bit inj_dp, input string req);
    logic [15:0] got = 0;
    bit cnt_ok = 1, kind_ok = 1;
    while (!frame_active) @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      got = {got[14:0], sdo};
      if (bit_cnt !== k[3:0]) cnt_ok = 0;
      if (cmd_active !== exp_cmd || data_active !== !exp_cmd || !frame_active) kind_ok = 0;
      if (k == inj_k) begin
        if (inj_cmd) begin cmd_wr = 1; cmd_wdata = inj_word; end
        if (inj_dp) set_dp = 1;
      end
      for (int j = 0; j < en_period; j++) begin
        @(negedge clk); cmd_wr = 0; set_dp = 0;
      end
    end
    chk(got === exp_word, req, "frame word", {16'h0, got}, {16'h0, exp_word});
    chk(kind_ok, "R11", "frame type flags", {31'h0, kind_ok}, 1);
    chk(cnt_ok, "R8", "bit counter sequence", {31'h0, cnt_ok}, 1);
  endtask

  task automatic t_reset();
    chk(!sdo && !frame_active && !cmd_active && !data_active && !cmd_pend && !data_pend
        && bit_cnt == 0, "R1", "reset state",
        {sdo, frame_active, cmd_active, data_active, cmd_pend, data_pend, bit_cnt}, 0);
  endtask

  task automatic t_cmd_idle();
    set_period(1);
    wr_cmd(16'hA5C3);
    capture(16'hA5C3, 1, -1, 0, 0, 0, "R2");
    check_idle("R7");
    set_period(0); @(negedge clk);
  endtask

  task automatic t_data_idle();
    wr_data(16'h1234);
    set_period(1);
    req_data();
    capture(16'h1234, 0, -1, 0, 0, 0, "R3");
    check_idle("R7");
    set_period(0); @(negedge clk);
  endtask

  task automatic t_priority();
    wr_data(16'h5A5A);
    wr_cmd(16'h00FF);
    req_data();
    chk(cmd_pend && data_pend, "R2", "both pending held", {cmd_pend, data_pend}, 2'b11);
    set_period(1);
    while (!frame_active) @(negedge clk);
    chk(!cmd_pend && data_pend, "R4", "cmd flag cleared on first bit", {cmd_pend, data_pend}, 2'b01);
    capture(16'h00FF, 1, 3, 1, 16'hF00D, 0, "R5");
    capture(16'hF00D, 1, -1, 0, 0, 0, "R5");
    chk(!data_pend, "R4", "data flag cleared on first bit", data_pend, 0);
    capture(16'h5A5A, 0, -1, 0, 0, 0, "R5");
    check_idle("R7");
    set_period(0); @(negedge clk);
  endtask

  task automatic t_defer();
    wr_data(16'hC001);
    set_period(1);
    req_data();
    capture(16'hC001, 0, 5, 1, 16'h7E81, 0, "R6");
    chk(cmd_active, "R6", "cmd follows back-to-back", cmd_active, 1);
    capture(16'h7E81, 1, -1, 0, 0, 0, "R6");
    check_idle("R7");
    set_period(0); @(negedge clk);
  endtask

  task automatic t_overwrite();
    wr_cmd(16'h1111);
    wr_cmd(16'hBEEF);
    chk(cmd_pend, "R10", "pending after two writes", cmd_pend, 1);
    set_period(1);
    capture(16'hBEEF, 1, -1, 0, 0, 0, "R10");
    chk(!frame_active && !cmd_pend, "R10", "single command frame",
        {frame_active, cmd_pend}, 0);
    set_period(0); @(negedge clk);
  endtask

  task automatic t_slow();
    wr_cmd(16'h8001);
    set_period(3);
    capture(16'h8001, 1, -1, 0, 0, 0, "R8");
    check_idle("R7");
    set_period(0); @(negedge clk);
  endtask

  task automatic t_repeat();
    wr_data(16'h0F0F);
    set_period(1);
    rep_mode = 1;
    capture(16'h0F0F, 0, 4, 1, 16'h3C3C, 0, "R9");
    capture(16'h3C3C, 1, -1, 0, 0, 0, "R9");
    capture(16'h0F0F, 0, -1, 0, 0, 0, "R9");
    chk(data_active && !data_pend, "R9", "data repeats without request",
        {data_active, data_pend}, 2'b10);
    rep_mode = 0;
    capture(16'h0F0F, 0, -1, 0, 0, 0, "R9");
    check_idle("R7");
    set_period(0); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cmd_idle();
    t_data_idle();
    t_priority();
    t_defer();
    t_overwrite();
    t_slow();
    t_repeat();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule